// File: doc/BRIEF.md
# Load/Store Ordering Tracker

This block follows memory operations from dispatch until they have executed, and decides when each of them may issue under a weak ordering model. Each operation is dispatched with a tag and three flags: may-load, may-store and side-effect. An operation that may load takes a slot in the load queue, and one that may store takes a slot in the store queue. An operation with both flags takes one slot in each queue. The side-effect flag turns a load-queue entry into a load barrier and a store-queue entry into a store barrier. With both memory flags it makes a full barrier. The dispatcher learns in the same cycle whether the operation was accepted or which queue was full.

A scheduler can query any tag and receives, one cycle later, whether that operation may issue now. Issue is allowed only when the ordering rules are met against all older entries. Age is judged from the dispatch tags. The caller hands these out in increasing order, and they are compared modulo 2^TAG_W. When an operation has executed, its tag is reported once and all its entries are released.

Top module: `lsq_order_tracker`

## Requirements
- R1: An accepted dispatch with may-load set takes one load-queue slot, and one with may-store set takes one store-queue slot. An operation with both flags takes one slot in each queue. A queue never holds more than its capacity parameter.
- R2: `disp_status` reads 0 when the operation is available, 1 when the load queue is full, and 2 when the store queue is full. If both queues would be needed and both are full, 1 is returned. An operation with neither memory flag always gets 0, and the value 3 never occurs.
- R3: A capacity parameter of 0 means that queue never reports full. That queue then has UNB_DEPTH physical slots, and the caller keeps the number in flight within that.
- R4: A dispatch whose status is not 0 records nothing. An executed report in the same cycle frees its slots only from the next cycle on, so the full check in that cycle still sees them.
- R5: A store is not ready while any older operation holds a load-queue or store-queue slot.
- R6: With NO_ALIAS = 0, a load is not ready while an older store-queue entry exists. With NO_ALIAS = 1, older stores do not block loads.
- R7: A load may pass older plain loads. It is not ready while an older load barrier is still in the load queue.
- R8: A barrier is ready only when it is the oldest entry in each queue it occupies. A load barrier needs no older load-queue entry, and a store barrier needs no older store-queue entry.
- R9: `exe_valid` with `exe_tag` releases every slot that holds that tag, together with its barrier mark. After that the operation blocks nothing.
- R10: A query for a tag that no queue holds answers ready.
- R11: A query in cycle N is answered on `rsp_valid`/`rsp_ready` after the rising edge that ends cycle N. The answer reflects the queue contents before that edge. `rsp_ready` is 0 when no query was made.
- R12: Tag a is older than tag b when bit TAG_W-1 of (a - b) mod 2^TAG_W is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Tag of the dispatched operation |
| disp_ld | input | 1 | Operation may load |
| disp_st | input | 1 | Operation may store |
| disp_fx | input | 1 | Operation has side effects |
| disp_status | output | 2 | Same-cycle status: 0 available, 1 load queue full, 2 store queue full |
| qry_valid | input | 1 | Readiness query |
| qry_tag | input | TAG_W | Tag being queried |
| rsp_valid | output | 1 | Registered: a query answer is present |
| rsp_ready | output | 1 | Registered: the queried operation may issue |
| exe_valid | input | 1 | Executed report |
| exe_tag | input | TAG_W | Tag of the executed operation |

## Verification
`disp_status` is combinational from the registered occupancy and the dispatch inputs, so it is due in the same cycle. The bench drives inputs at the falling edge and reads the status 1 ns later. The query answer is due after one rising edge. The bench computes the expectation from its own model of the queues before that edge, then applies the edge's dispatch and release to the model. It compares `rsp_valid` and `rsp_ready` at the next falling edge, so the effects of the same cycle never leak into an answer.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    ST_AVAIL   = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2
  } disp_stat_e;

  // summary of one queue as seen from the queried tag
  typedef struct packed {
    logic hit;        // tag is held in this queue
    logic hit_bar;    // and that entry is a barrier
    logic older_any;  // some older entry exists
    logic older_bar;  // some older barrier entry exists
  } bank_probe_t;

endpackage

// File: rtl/lsq_free_pick.sv
module lsq_free_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest-numbered free slot
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lsq_slot_bank.sv
module lsq_slot_bank
  import lsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             alloc_bar,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output bank_probe_t      probe,
  output logic [CNT_W-1:0] count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] bar;
  logic [TAG_W-1:0] tags [DEPTH];

  logic             slot_found;
  logic [IDX_W-1:0] slot_idx;
  logic             alloc_ok;
  logic [DEPTH-1:0] free_match;
  logic             free_hit;

  lsq_free_pick #(.N(DEPTH), .IDX_W(IDX_W)) pick_i (
    .busy  (valid),
    .found (slot_found),
    .idx   (slot_idx)
  );

  assign alloc_ok = alloc_en && slot_found;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign free_match[g] = free_en && valid[g] && (tags[g] == free_tag);
    end
  endgenerate

  assign free_hit = |free_match;

  // tag storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      tags[slot_idx] <= alloc_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      bar   <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_match[i]) begin
          valid[i] <= 1'b0;
          bar[i]   <= 1'b0;
        end
      end
      if (alloc_ok) begin
        valid[slot_idx] <= 1'b1;
        bar[slot_idx]   <= alloc_bar;
      end
      count <= count + CNT_W'(alloc_ok) - CNT_W'(free_hit);
    end
  end

  // age probe against the queried tag, wrap-safe
  always_comb begin
    logic [TAG_W-1:0] diff;
    logic             older;
    logic             same;
    probe = '0;
    for (int i = 0; i < DEPTH; i++) begin
      diff  = tags[i] - probe_tag;
      older = valid[i] && diff[TAG_W-1];
      same  = valid[i] && (tags[i] == probe_tag);
      probe.hit       = probe.hit | same;
      probe.hit_bar   = probe.hit_bar | (same & bar[i]);
      probe.older_any = probe.older_any | older;
      probe.older_bar = probe.older_bar | (older & bar[i]);
    end
  end
endmodule

// File: rtl/lsq_ready_rule.sv
module lsq_ready_rule
  import lsq_pkg::*;
#(
  parameter bit NO_ALIAS = 1'b0
) (
  input  bank_probe_t lq_pr,
  input  bank_probe_t sq_pr,
  output logic        ready
);
  always_comb begin
    ready = 1'b1;
    if (sq_pr.hit) begin
      // stores stay behind every older load and store
      if (sq_pr.older_any || lq_pr.older_any) ready = 1'b0;
    end
    if (lq_pr.hit) begin
      if (lq_pr.older_bar) ready = 1'b0;
      if (!NO_ALIAS && sq_pr.older_any) ready = 1'b0;
      // a load barrier issues only as the oldest load entry
      if (lq_pr.hit_bar && lq_pr.older_any) ready = 1'b0;
    end
  end
endmodule

// File: rtl/lsq_order_tracker.sv
module lsq_order_tracker
  import lsq_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter int LQ_CAP    = 4,
  parameter int SQ_CAP    = 4,
  parameter int UNB_DEPTH = 8,
  parameter bit NO_ALIAS  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             disp_ld,
  input  logic             disp_st,
  input  logic             disp_fx,
  output logic [1:0]       disp_status,
  input  logic             qry_valid,
  input  logic [TAG_W-1:0] qry_tag,
  output logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             exe_valid,
  input  logic [TAG_W-1:0] exe_tag
);
  localparam int LQ_DEPTH = (LQ_CAP == 0) ? UNB_DEPTH : LQ_CAP;
  localparam int SQ_DEPTH = (SQ_CAP == 0) ? UNB_DEPTH : SQ_CAP;
  localparam int LQ_CW    = $clog2(LQ_DEPTH + 1);
  localparam int SQ_CW    = $clog2(SQ_DEPTH + 1);

  logic [LQ_CW-1:0] lq_cnt;
  logic [SQ_CW-1:0] sq_cnt;
  logic             lq_full;
  logic             sq_full;
  disp_stat_e       stat;
  logic             accept;
  bank_probe_t      lq_pr;
  bank_probe_t      sq_pr;
  logic             rdy;

  generate
    if (LQ_CAP == 0) begin : g_lq_open
      assign lq_full = 1'b0;
    end else begin : g_lq_cap
      assign lq_full = (lq_cnt == LQ_CW'(LQ_CAP));
    end
    if (SQ_CAP == 0) begin : g_sq_open
      assign sq_full = 1'b0;
    end else begin : g_sq_cap
      assign sq_full = (sq_cnt == SQ_CW'(SQ_CAP));
    end
  endgenerate

  always_comb begin
    stat = ST_AVAIL;
    if (disp_valid) begin
      if (disp_ld && lq_full)      stat = ST_LQ_FULL;
      else if (disp_st && sq_full) stat = ST_SQ_FULL;
    end
  end

  assign disp_status = stat;
  assign accept      = disp_valid && (stat == ST_AVAIL);

  lsq_slot_bank #(.DEPTH(LQ_DEPTH), .TAG_W(TAG_W), .CNT_W(LQ_CW)) lq_i (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept && disp_ld),
    .alloc_tag (disp_tag),
    .alloc_bar (disp_fx),
    .free_en   (exe_valid),
    .free_tag  (exe_tag),
    .probe_tag (qry_tag),
    .probe     (lq_pr),
    .count     (lq_cnt)
  );

  lsq_slot_bank #(.DEPTH(SQ_DEPTH), .TAG_W(TAG_W), .CNT_W(SQ_CW)) sq_i (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept && disp_st),
    .alloc_tag (disp_tag),
    .alloc_bar (disp_fx),
    .free_en   (exe_valid),
    .free_tag  (exe_tag),
    .probe_tag (qry_tag),
    .probe     (sq_pr),
    .count     (sq_cnt)
  );

  lsq_ready_rule #(.NO_ALIAS(NO_ALIAS)) rule_i (
    .lq_pr (lq_pr),
    .sq_pr (sq_pr),
    .ready (rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ready <= 1'b0;
    end else begin
      rsp_valid <= qry_valid;
      rsp_ready <= qry_valid && rdy;
    end
  end
endmodule

// File: rtl/lsq_order_tracker_chk.sv
module lsq_order_tracker_chk #(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  parameter int LQ_CW    = 3,
  parameter int SQ_CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic             disp_ld,
  input logic             disp_st,
  input logic [1:0]       disp_status,
  input logic             qry_valid,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             exe_valid,
  input logic [LQ_CW-1:0] lq_cnt,
  input logic [SQ_CW-1:0] sq_cnt,
  input logic             lq_hit,
  input logic             lq_older,
  input logic             sq_hit,
  input logic             sq_older
);
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    disp_status != 2'd3); // R2
  AST_NONMEM_AVAIL: assert property (@(posedge clk) disable iff (rst)
    disp_valid && !disp_ld && !disp_st |-> disp_status == 2'd0); // R2
  AST_LQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    lq_cnt <= LQ_CW'(LQ_DEPTH)); // R1
  AST_SQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    sq_cnt <= SQ_CW'(SQ_DEPTH)); // R1
  AST_LQ_GROWS: assert property (@(posedge clk) disable iff (rst)
    disp_valid && disp_ld && disp_status == 2'd0 && !exe_valid && lq_cnt < LQ_CW'(LQ_DEPTH)
    |=> lq_cnt == LQ_CW'($past(lq_cnt) + 1'b1)); // R1
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    disp_valid && disp_status != 2'd0 && !exe_valid
    |=> lq_cnt == $past(lq_cnt) && sq_cnt == $past(sq_cnt)); // R4
  AST_EXEC_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    exe_valid && !disp_valid |=> lq_cnt <= $past(lq_cnt) && sq_cnt <= $past(sq_cnt)); // R9
  AST_ABSENT_READY: assert property (@(posedge clk) disable iff (rst)
    qry_valid && !lq_hit && !sq_hit |=> rsp_valid && rsp_ready); // R10
  AST_STORE_WAITS: assert property (@(posedge clk) disable iff (rst)
    qry_valid && sq_hit && (sq_older || lq_older) |=> !rsp_ready); // R5
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !rsp_valid && !rsp_ready); // R11
endmodule

bind lsq_order_tracker lsq_order_tracker_chk #(
  .LQ_DEPTH (LQ_DEPTH),
  .SQ_DEPTH (SQ_DEPTH),
  .LQ_CW    (LQ_CW),
  .SQ_CW    (SQ_CW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .disp_valid  (disp_valid),
  .disp_ld     (disp_ld),
  .disp_st     (disp_st),
  .disp_status (disp_status),
  .qry_valid   (qry_valid),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .exe_valid   (exe_valid),
  .lq_cnt      (lq_cnt),
  .sq_cnt      (sq_cnt),
  .lq_hit      (lq_pr.hit),
  .lq_older    (lq_pr.older_any),
  .sq_hit      (sq_pr.hit),
  .sq_older    (sq_pr.older_any)
);

// File: tb/lsq_order_tracker_tb_top.sv
`timescale 1ns/1ps
module lsq_order_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       disp_valid = 0, disp_ld = 0, disp_st = 0, disp_fx = 0;
  logic [5:0] disp_tag = 0;
  logic [1:0] disp_status;
  logic       qry_valid = 0;
  logic [5:0] qry_tag = 0;
  logic       rsp_valid, rsp_ready;
  logic       exe_valid = 0;
  logic [5:0] exe_tag = 0;

  lsq_order_tracker #(.TAG_W(6), .LQ_CAP(4), .SQ_CAP(4), .UNB_DEPTH(8), .NO_ALIAS(1'b0)) dut_i (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_ld(disp_ld),
    .disp_st(disp_st), .disp_fx(disp_fx), .disp_status(disp_status), .qry_valid(qry_valid),
    .qry_tag(qry_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .exe_valid(exe_valid),
    .exe_tag(exe_tag));

  // second instance: open capacity, loads ignore stores
  logic       u_dv = 0, u_ld = 0, u_st = 0, u_qv = 0;
  logic [5:0] u_dt = 0, u_qt = 0;
  logic [1:0] u_stat;
  logic       u_rv, u_rr;

  lsq_order_tracker #(.TAG_W(6), .LQ_CAP(0), .SQ_CAP(0), .UNB_DEPTH(8), .NO_ALIAS(1'b1)) dut_u_i (
    .clk(clk), .rst(rst), .disp_valid(u_dv), .disp_tag(u_dt), .disp_ld(u_ld),
    .disp_st(u_st), .disp_fx(1'b0), .disp_status(u_stat), .qry_valid(u_qv),
    .qry_tag(u_qt), .rsp_valid(u_rv), .rsp_ready(u_rr), .exe_valid(1'b0),
    .exe_tag(6'd0));

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- reference model of in-flight operations ----------------
  logic       mv [16];
  logic [5:0] mt [16];
  logic       ml [16], ms [16], mf [16];
  logic [5:0] nxt_tag = 0;

  function automatic logic older(input logic [5:0] a, input logic [5:0] b); // R12
    logic [5:0] d;
    d = a - b;
    return d[5];
  endfunction

  function automatic int occ(input bit want_load);
    int n = 0;
    for (int i = 0; i < 16; i++)
      if (mv[i] && (want_load ? ml[i] : ms[i])) n++;
    return n;
  endfunction

  function automatic int exp_status(input logic v, input logic l, input logic s);
    if (!v) return 0;
    if (l && occ(1'b1) >= 4) return 1;
    if (s && occ(1'b0) >= 4) return 2;
    return 0;
  endfunction

  function automatic int find(input logic [5:0] t);
    for (int i = 0; i < 16; i++)
      if (mv[i] && mt[i] == t && (ml[i] || ms[i])) return i;
    return -1;
  endfunction

  function automatic logic exp_ready(input logic [5:0] t);
    int j;
    logic r;
    j = find(t);
    if (j < 0) return 1'b1;                                   // R10
    r = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (k != j && mv[k] && older(mt[k], mt[j])) begin
        if (ms[j] && (ml[k] || ms[k])) r = 1'b0;              // R5, R8
        if (ml[j] && ms[k]) r = 1'b0;                         // R6
        if (ml[j] && ml[k] && mf[k]) r = 1'b0;                // R7
        if (ml[j] && mf[j] && ml[k]) r = 1'b0;                // R8
      end
    end
    return r;
  endfunction

  function automatic int nvalid();
    int n = 0;
    for (int i = 0; i < 16; i++) if (mv[i]) n++;
    return n;
  endfunction

  function automatic int pick_valid();
    int n, r;
    n = nvalid();
    r = $urandom % n;
    for (int i = 0; i < 16; i++) begin
      if (mv[i]) begin
        if (r == 0) return i;
        r--;
      end
    end
    return 0;
  endfunction

  function automatic int oldest_idx();
    int o = -1;
    for (int i = 0; i < 16; i++)
      if (mv[i] && (o < 0 || older(mt[i], mt[o]))) o = i;
    return o;
  endfunction

  // one cycle: drive at falling edge, check status, pass the edge, check answer
  task automatic step(input logic v, l, s, f, input logic ev, input logic [5:0] et,
                      input logic qv, input logic [5:0] qt, input string note);
    int   es;
    logic er;
    disp_valid = v; disp_ld = l; disp_st = s; disp_fx = f; disp_tag = nxt_tag;
    exe_valid = ev; exe_tag = et; qry_valid = qv; qry_tag = qt;
    #1;
    es = exp_status(v, l, s);
    chk(disp_status == 2'(es), {"R2 status ", note}, disp_status, es);
    er = qv ? exp_ready(qt) : 1'b0;
    @(posedge clk);
    if (ev) begin
      for (int i = 0; i < 16; i++) if (mv[i] && mt[i] == et) mv[i] = 1'b0;  // R9
    end
    if (v && es == 0 && (l || s)) begin
      for (int i = 0; i < 16; i++) begin
        if (!mv[i]) begin
          mv[i] = 1'b1; mt[i] = nxt_tag; ml[i] = l; ms[i] = s; mf[i] = f;
          break;
        end
      end
    end
    if (v && es == 0) nxt_tag = nxt_tag + 6'd1;
    @(negedge clk);
    chk(rsp_valid == qv, {"R11 rsp_valid ", note}, rsp_valid, qv);
    chk(rsp_ready == er, {"R11 rsp_ready ", note}, rsp_ready, er);
  endtask

  task automatic dsp(input logic l, s, f, input string note);
    step(1'b1, l, s, f, 1'b0, 6'd0, 1'b0, 6'd0, note);
  endtask
  task automatic qry(input logic [5:0] t, input string note);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1, t, note);
  endtask
  task automatic exe(input logic [5:0] t, input string note);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, t, 1'b0, 6'd0, note);
  endtask

  task automatic drain();
    for (int i = 0; i < 16; i++) if (mv[i]) exe(mt[i], "R9 drain");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] rej;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mt[i] = 0; ml[i] = 0; ms[i] = 0; mf[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", rsp_valid, 0);
    chk(rsp_ready == 1'b0, "R11 reset rsp_ready", rsp_ready, 0);
    chk(disp_status == 2'd0, "R2 reset status", disp_status, 0);

    qry(6'd9, "R10 empty tracker");
    dsp(1'b1, 1'b0, 1'b0, "load t0");
    dsp(1'b1, 1'b0, 1'b0, "load t1");
    qry(6'd1, "R7 load passes older load");
    dsp(1'b0, 1'b1, 1'b0, "store t2");
    dsp(1'b1, 1'b0, 1'b0, "load t3");
    qry(6'd3, "R6 load behind older store");
    qry(6'd2, "R5 store behind older loads");
    exe(6'd0, "R9 free t0");
    exe(6'd1, "R9 free t1");
    qry(6'd2, "R5 store now oldest");
    exe(6'd2, "R9 free t2");
    dsp(1'b1, 1'b0, 1'b1, "load barrier t4");
    dsp(1'b1, 1'b0, 1'b0, "load t5");
    qry(6'd4, "R8 barrier with older load");
    qry(6'd5, "R7 load behind barrier");
    exe(6'd3, "R9 free t3");
    qry(6'd4, "R8 barrier oldest");
    dsp(1'b1, 1'b1, 1'b1, "full barrier t6");
    qry(6'd6, "R8 full barrier behind loads");
    drain();
    dsp(1'b0, 1'b1, 1'b1, "store barrier");
    dsp(1'b0, 1'b1, 1'b0, "store after barrier");
    qry(nxt_tag - 6'd1, "R5 store behind store barrier");
    qry(nxt_tag - 6'd2, "R8 store barrier oldest");
    drain();

    // capacity and status
    for (int i = 0; i < 4; i++) dsp(1'b1, 1'b0, 1'b0, "R1 fill loads");
    dsp(1'b1, 1'b0, 1'b0, "R2 load queue full");
    dsp(1'b1, 1'b1, 1'b0, "R2 load first when both");
    for (int i = 0; i < 4; i++) dsp(1'b0, 1'b1, 1'b0, "R1 fill stores");
    dsp(1'b0, 1'b1, 1'b0, "R2 store queue full");
    dsp(1'b1, 1'b1, 1'b0, "R2 both full");
    dsp(1'b0, 1'b0, 1'b1, "R2 non-memory");
    // same-cycle release does not help this cycle's check
    rej = nxt_tag;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, mt[oldest_idx()], 1'b0, 6'd0, "R4 release same cycle");
    qry(rej, "R4 rejected tag absent");
    dsp(1'b1, 1'b0, 1'b0, "R4 accepted next cycle");
    drain();

    // open-capacity, no-alias instance
    begin
      logic [1:0] s0;
      for (int i = 0; i < 7; i++) begin
        u_dv = 1'b1; u_dt = 6'(i); u_ld = (i != 0); u_st = (i == 0);
        #1;
        s0 = u_stat;
        chk(s0 == 2'd0, "R3 open capacity status", s0, 0);
        @(negedge clk);
      end
      u_dv = 1'b0;
      u_qv = 1'b1; u_qt = 6'd1;
      @(negedge clk);
      chk(u_rr == 1'b1, "R6 no-alias load passes store", u_rr, 1);
      u_qt = 6'd6;
      @(negedge clk);
      chk(u_rr == 1'b1, "R7 no-alias later load ready", u_rr, 1);
      u_qt = 6'd0;
      @(negedge clk);
      chk(u_rr == 1'b1, "R5 oldest store ready", u_rr, 1);
      u_qv = 1'b0;
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic v, l, s, f, ev, qv;
      logic [5:0] et, qt;
      int k, oi;
      k  = $urandom % 4;
      v  = ($urandom % 3) != 0;
      l  = (k == 0 || k == 2);
      s  = (k == 1 || k == 2);
      f  = ($urandom % 4) == 0;
      oi = oldest_idx();
      ev = 1'b0; et = 6'd0;
      if (oi >= 0 && (6'(nxt_tag - mt[oi]) >= 6'd20)) begin
        ev = 1'b1; et = mt[oi];
      end else if (nvalid() > 0 && ($urandom % 3) == 0) begin
        ev = 1'b1; et = mt[pick_valid()];
      end
      qv = ($urandom % 8) != 0;
      if (nvalid() > 0 && ($urandom % 4) != 0) qt = mt[pick_valid()];
      else qt = nxt_tag + 6'd5;
      step(v, l, s, f, ev, et, qv, qt, "R12 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule